// File: doc/BRIEF.md
# Per-Sprite Pattern Bank Translator

This block gives each of the 64 hardware sprites its own pattern bank. A table with one 16-bit bank number per sprite is loaded by the CPU one byte at a time, through two 64-byte register windows. One window holds the upper bytes and the other holds the lower bytes. During the sprite pattern fetch phase, the video side announces which sprite it is about to fetch. The block latches that sprite number, reads the sprite's bank from the table and builds the pattern memory address from it.

The bank is shifted by the size of one sprite's pattern span, which depends on the sprite height: 12 bits for 8x8 sprites and 13 bits for 8x16 sprites. The pattern offset is then added to it. When the extended mode is off, when rendering is off, or outside the sprite fetch phase, the address from the ordinary shared banking logic passes through unchanged. The result is registered, so `fetch_addr` reflects the inputs sampled at the previous clock edge.

Top module: `spr_bank_xlate`

## Requirements
- R1: During and after reset, extended mode is off and every table entry is zero. While reset is asserted, `fetch_addr` is 0.
- R2: A CPU write to an address from 0x4200 to 0x423F sets bits 15:8 of entry (address − 0x4200) to the write data. Bits 7:0 of that entry are left unchanged.
- R3: A CPU write to an address from 0x4240 to 0x427F sets bits 7:0 of entry (address − 0x4240) to the write data. Bits 15:8 of that entry are left unchanged.
- R4: When extended mode is on, rendering is on, the sprite fetch phase is active and `tall_spr`=0, `fetch_addr` equals (bank << 12) + `pat_addr`.
- R5: Under the same conditions with `tall_spr`=1, `fetch_addr` equals (bank << 13) + `pat_addr`.
- R6: When extended mode is off, `render_on`=0 or `obj_phase`=0, `fetch_addr` equals `dflt_addr`.
- R7: When `spr_start`=1, the table index becomes `spr_num`, and that same cycle already uses it. While `spr_start`=0, the previously latched index is used and changes on `spr_num` have no effect.
- R8: A CPU write to the entry being read in the same cycle does not affect that cycle's address, which uses the old entry value. The next cycle uses the new value.
- R9: CPU writes outside 0x4200 to 0x427F leave every entry unchanged.
- R10: `cfg_wr`=1 loads `cfg_ext_mode` as the extended-mode enable (1 = on), effective from the next cycle. `fetch_addr` is registered and is valid one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cfg_wr | input | 1 | Load strobe for the extended-mode enable |
| cfg_ext_mode | input | 1 | New extended-mode enable value |
| render_on | input | 1 | Rendering enabled |
| obj_phase | input | 1 | Sprite pattern fetch phase active |
| tall_spr | input | 1 | 1 = 8x16 sprites, 0 = 8x8 sprites |
| spr_start | input | 1 | Start of a sprite's pattern fetches; latch `spr_num` |
| spr_num | input | 6 | Number of the sprite being fetched |
| pat_addr | input | 13 | Pattern address offset from the video side |
| dflt_addr | input | 29 | Address from the ordinary shared banking logic |
| fetch_addr | output | 29 | Registered pattern memory address |

## Verification
A CPU table write and a video lookup can land in the same cycle on the same entry. The bench provokes this by writing the high byte of sprite 7 in the same cycle that `spr_start` selects sprite 7. The scoreboard expects that cycle's address to be built from the old entry value, and the following cycle's address to be built from the new one. The bench also pairs `spr_start` with an index-latch change, and then varies `spr_num` without a start pulse, to show that only the latched number selects the entry.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
    // Which source drives the fetch address
    typedef enum logic [1:0] {
        PATH_DFLT  = 2'd0,
        PATH_SHORT = 2'd1,
        PATH_TALL  = 2'd2
    } path_e;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/sbt_table.sv
module sbt_table
    import sbt_pkg::*;
#(
    parameter int              NUM_SPR  = 64,
    parameter int              BANK_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4200,
    localparam int             IDX_W    = $clog2(NUM_SPR),
    localparam int             HI_W     = BANK_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BANK_W-1:0] rd_bank
);
    typedef struct packed {
        logic [NUM_SPR-1:0][BANK_W-1:0] tbl;
    } tbl_st_t;

    tbl_st_t           st_d, st_q;
    logic [ADDR_W-1:0] offs;
    logic              hi_hit, lo_hit;
    logic [IDX_W-1:0]  w_idx;

    always_comb begin
        offs   = cpu_addr - WIN_BASE;
        hi_hit = cpu_wr && (offs < ADDR_W'(NUM_SPR));
        lo_hit = cpu_wr && (offs >= ADDR_W'(NUM_SPR)) && (offs < ADDR_W'(2 * NUM_SPR));
        w_idx  = offs[IDX_W-1:0];
        st_d   = st_q;
        if (hi_hit) st_d.tbl[w_idx][BANK_W-1:BYTE_W] = cpu_wdata[HI_W-1:0];
        if (lo_hit) st_d.tbl[w_idx][BYTE_W-1:0]      = cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read sees the registered value: a same-cycle write is not visible yet
    assign rd_bank = st_q.tbl[rd_idx];

    // R2
    hi_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_hit |=> (st_q.tbl[$past(w_idx)][BANK_W-1:BYTE_W] == $past(cpu_wdata[HI_W-1:0]))
                && (st_q.tbl[$past(w_idx)][BYTE_W-1:0] == $past(st_q.tbl[w_idx][BYTE_W-1:0])));

    // R3
    lo_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_hit |=> (st_q.tbl[$past(w_idx)][BYTE_W-1:0] == $past(cpu_wdata))
                && (st_q.tbl[$past(w_idx)][BANK_W-1:BYTE_W] == $past(st_q.tbl[w_idx][BANK_W-1:BYTE_W])));

    // R9
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_hit || lo_hit) |=> $stable(st_q.tbl));
endmodule

// File: rtl/sbt_index.sv
module sbt_index #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spr_start,
    input  logic [IDX_W-1:0] spr_num,
    output logic [IDX_W-1:0] cur_idx
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_st_t;

    idx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (spr_start) st_d.idx = spr_num;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The starting cycle already uses the new sprite number
    assign cur_idx = spr_start ? spr_num : st_q.idx;

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spr_start |=> $stable(st_q.idx));

    // R7
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_start |=> st_q.idx == $past(spr_num));
endmodule

// File: rtl/sbt_addr.sv
module sbt_addr
    import sbt_pkg::*;
#(
    parameter int BANK_W = 16,
    parameter int PAT_AW = 13,
    localparam int OUT_W    = BANK_W + PAT_AW,
    localparam int SHORT_SH = PAT_AW - 1,
    localparam int TALL_SH  = PAT_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_on,
    input  logic              render_on,
    input  logic              obj_phase,
    input  logic              tall_spr,
    input  logic [BANK_W-1:0] bank,
    input  logic [PAT_AW-1:0] pat_addr,
    input  logic [OUT_W-1:0]  dflt_addr,
    output logic [OUT_W-1:0]  fetch_addr
);
    typedef struct packed {
        logic [OUT_W-1:0] addr;
    } out_st_t;

    out_st_t          st_d, st_q;
    path_e            path;
    logic [OUT_W-1:0] bank_w, pat_w;

    always_comb begin
        bank_w = OUT_W'(bank);
        pat_w  = OUT_W'(pat_addr);
        path   = PATH_DFLT;
        if (ext_on && render_on && obj_phase)
            path = tall_spr ? PATH_TALL : PATH_SHORT;
        st_d = st_q;
        case (path)
            PATH_SHORT: st_d.addr = (bank_w << SHORT_SH) + pat_w;
            PATH_TALL:  st_d.addr = (bank_w << TALL_SH) + pat_w;
            default:    st_d.addr = dflt_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr = st_q.addr;

    // R4
    short_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_on && render_on && obj_phase && !tall_spr)
        |=> fetch_addr == ((OUT_W'($past(bank)) << SHORT_SH) + OUT_W'($past(pat_addr))));

    // R5
    tall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_on && render_on && obj_phase && tall_spr)
        |=> fetch_addr == ((OUT_W'($past(bank)) << TALL_SH) + OUT_W'($past(pat_addr))));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_on && render_on && obj_phase) |=> fetch_addr == $past(dflt_addr));
endmodule

// File: rtl/spr_bank_xlate.sv
module spr_bank_xlate
    import sbt_pkg::*;
#(
    parameter int                NUM_SPR  = 64,
    parameter int                BANK_W   = 16,
    parameter int                PAT_AW   = 13,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4200,
    localparam int               IDX_W    = $clog2(NUM_SPR),
    localparam int               OUT_W    = BANK_W + PAT_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_ext_mode,
    input  logic              render_on,
    input  logic              obj_phase,
    input  logic              tall_spr,
    input  logic              spr_start,
    input  logic [IDX_W-1:0]  spr_num,
    input  logic [PAT_AW-1:0] pat_addr,
    input  logic [OUT_W-1:0]  dflt_addr,
    output logic [OUT_W-1:0]  fetch_addr
);
    typedef struct packed {
        logic ext;
    } cfg_st_t;

    cfg_st_t           cfg_d, cfg_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [BANK_W-1:0] cur_bank;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) cfg_d.ext = cfg_ext_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // R10
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_q.ext == $past(cfg_ext_mode));

    sbt_index #(.IDX_W(IDX_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .spr_start (spr_start),
        .spr_num   (spr_num),
        .cur_idx   (cur_idx)
    );

    sbt_table #(.NUM_SPR(NUM_SPR), .BANK_W(BANK_W), .WIN_BASE(WIN_BASE)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .rd_idx    (cur_idx),
        .rd_bank   (cur_bank)
    );

    sbt_addr #(.BANK_W(BANK_W), .PAT_AW(PAT_AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_on     (cfg_q.ext),
        .render_on  (render_on),
        .obj_phase  (obj_phase),
        .tall_spr   (tall_spr),
        .bank       (cur_bank),
        .pat_addr   (pat_addr),
        .dflt_addr  (dflt_addr),
        .fetch_addr (fetch_addr)
    );
endmodule

// File: tb/spr_bank_xlate_test.sv
module spr_bank_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_ext_mode = 1'b0;
    logic        render_on = 1'b0;
    logic        obj_phase = 1'b0;
    logic        tall_spr = 1'b0;
    logic        spr_start = 1'b0;
    logic [5:0]  spr_num = '0;
    logic [12:0] pat_addr = '0;
    logic [28:0] dflt_addr = '0;
    logic [28:0] fetch_addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    spr_bank_xlate uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cfg_wr(cfg_wr), .cfg_ext_mode(cfg_ext_mode),
        .render_on(render_on), .obj_phase(obj_phase), .tall_spr(tall_spr),
        .spr_start(spr_start), .spr_num(spr_num), .pat_addr(pat_addr),
        .dflt_addr(dflt_addr), .fetch_addr(fetch_addr)
    );

    // Bench model, built from the requirements
    logic [15:0] mdl [64];
    logic        mdl_ext = 1'b0;
    logic [5:0]  mdl_idx = '0;

    // Scoreboard queues
    logic [28:0] exp_q [$];
    string       tag_q [$];

    task automatic step(input string tag, input bit wr, input logic [15:0] a,
                        input logic [7:0] d, input bit cw, input bit ce,
                        input bit ren, input bit obj, input bit tall,
                        input bit st, input logic [5:0] num,
                        input logic [12:0] pat, input logic [28:0] dflt);
        logic [5:0]  use_idx;
        logic [63:0] e;
        @(negedge clk);
        cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        cfg_wr = cw; cfg_ext_mode = ce;
        render_on = ren; obj_phase = obj; tall_spr = tall;
        spr_start = st; spr_num = num; pat_addr = pat; dflt_addr = dflt;
        use_idx = st ? num : mdl_idx;
        if (mdl_ext && ren && obj)
            e = (64'(mdl[use_idx]) << (tall ? 13 : 12)) + 64'(pat);
        else
            e = 64'(dflt);
        exp_q.push_back(e[28:0]);
        tag_q.push_back(tag);
        if (st) mdl_idx = num;
        if (cw) mdl_ext = ce;
        if (wr && a >= 16'h4200 && a <= 16'h423F) mdl[a - 16'h4200][15:8] = d;
        if (wr && a >= 16'h4240 && a <= 16'h427F) mdl[a - 16'h4240][7:0] = d;
    endtask

    task automatic cpu(input string tag, input logic [15:0] a, input logic [7:0] d);
        step(tag, 1'b1, a, d, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 13'h0, 29'h0ABC);
    endtask

    task automatic fetch(input string tag, input bit ren, input bit obj, input bit tall,
                         input bit st, input logic [5:0] num, input logic [12:0] pat,
                         input logic [28:0] dflt);
        step(tag, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, ren, obj, tall, st, num, pat, dflt);
    endtask

    // Monitor: output after each edge reflects the inputs driven before it (R10)
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [28:0] ev;
            string       tg;
            ev = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (fetch_addr !== ev) begin
                fails++;
                $display("FAIL %s: fetch_addr actual %h expected %h", tg, fetch_addr, ev);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (fetch_addr !== 29'h0) begin
            fails++;
            $display("FAIL R1: reset fetch_addr actual %h expected 0", fetch_addr);
        end
        rst_n = 1'b1;

        // R1: mode off after reset, table zero
        fetch("R1 mode off", 1, 1, 0, 1, 6'd5, 13'h0A5, 29'h1111111);
        step("R1 entry zero", 0, 0, 0, 1, 1, 0, 0, 0, 0, 6'd0, 0, 29'h0222);
        fetch("R1 zero bank", 1, 1, 0, 1, 6'd9, 13'h1F0, 29'h0333);

        // Load entries
        cpu("R2 hi 5", 16'h4205, 8'h12);
        cpu("R3 lo 5", 16'h4245, 8'h34);
        cpu("R2 hi 63", 16'h423F, 8'hAB);
        cpu("R3 lo 63", 16'h427F, 8'hCD);
        cpu("R3 lo 0", 16'h4240, 8'h77);
        cpu("R2 hi 7", 16'h4207, 8'h01);
        cpu("R3 lo 7", 16'h4247, 8'h02);

        fetch("R4 short 5", 1, 1, 0, 1, 6'd5, 13'h00A5, 29'h0);
        fetch("R5 tall 63", 1, 1, 1, 1, 6'd63, 13'h1FFF, 29'h0);
        fetch("R4 short 0", 1, 1, 0, 1, 6'd0, 13'h0FFF, 29'h0);

        // R6: render off / not sprite phase
        fetch("R6 render off", 0, 1, 0, 1, 6'd5, 13'h0010, 29'h1ABCDEF);
        fetch("R6 bg phase", 1, 0, 1, 1, 6'd63, 13'h0010, 29'h0FEDCBA);

        // R7: index held without start
        fetch("R7 latch 5", 1, 1, 0, 1, 6'd5, 13'h0001, 29'h0);
        fetch("R7 num ignored", 1, 1, 0, 0, 6'd63, 13'h0002, 29'h0);
        fetch("R7 num ignored tall", 1, 1, 1, 0, 6'd0, 13'h0003, 29'h0);

        // R8: write and read of entry 7 in one cycle
        step("R8 old value", 1, 16'h4207, 8'hF0, 0, 0, 1, 1, 0, 1, 6'd7, 13'h0044, 29'h0);
        fetch("R8 new value", 1, 1, 0, 0, 6'd7, 13'h0044, 29'h0);

        // R9: writes just outside the window
        cpu("R9 below", 16'h41FF, 8'hEE);
        cpu("R9 above", 16'h4280, 8'hEE);
        fetch("R9 entry 63", 1, 1, 0, 1, 6'd63, 13'h0, 29'h0);
        fetch("R9 entry 0", 1, 1, 0, 1, 6'd0, 13'h0, 29'h0);

        // R2/R3: one half rewritten, other half kept
        cpu("R2 hi only", 16'h4205, 8'h9C);
        fetch("R2 lo kept", 1, 1, 1, 1, 6'd5, 13'h0100, 29'h0);
        cpu("R3 lo only", 16'h427F, 8'h00);
        fetch("R3 hi kept", 1, 1, 1, 1, 6'd63, 13'h0100, 29'h0);

        // R10: disable takes effect one cycle later
        step("R10 still on", 0, 0, 0, 1, 0, 1, 1, 0, 1, 6'd5, 13'h0005, 29'h0555);
        fetch("R10 now off", 1, 1, 0, 1, 6'd5, 13'h0005, 29'h0555);

        @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule